// File: doc/BRIEF.md
# Staged Thermal Derating Controller

This block protects the hot spots of a multi-port powered-Ethernet node: the connector zone, the switch FETs, the case and the inlet. It takes four digital temperature readings and tracks the hottest one. That reading drives a single global derating level: normal, stage 1, stage 2 or stage 3. Each level has its own set of actions, and the block turns the level into per-port controls:

- a power cap
- a burst-allow flag
- a flag that freezes upward power negotiation
- a port-off signal
- one global request to slow retries

Thresholds, hold time, restore spacing and the per-port attributes are plain register inputs. The per-port attributes are the critical flag, the high-power tag, the guaranteed floor and the maximum cap.

Escalation takes effect on the next clock edge and may skip levels. Relief is slower. The level falls one step at a time, and only after the reading has stayed below the current level's threshold for a programmed hold time. When the level falls, the ports do not recover together. Each port keeps the treatment it had until it is released. Releases happen one port per fixed interval, low-power ports first and high-power ports last. Every level change produces a one-cycle event carrying a direction flag, the level concerned and a free-running timestamp. A logging unit can capture these events.

Top module: `thermal_derate_ctrl`

## Requirements
- R1: The stage is computed from the highest of the four readings. Sensor k occupies bits k*TW and up of `temp_flat`. A reading equal to a threshold counts as crossing it. Stage codes are 0 for normal and 1, 2, 3 for the derate stages, with thresholds `thr_t1`, `thr_t2`, `thr_t3`.
- R2: When the hottest reading maps to a stage above the current one, `stage` takes that value on the next clock edge, even if it skips levels.
- R3: The stage falls by exactly one level once the hottest reading has been below the current stage's threshold on `hold_cycles`+1 consecutive clock edges. Any edge at or above that threshold restarts the count.
- R4: A port treated at stage 1 or higher has `burst_ok` low and `neg_freeze` high. At stage 1 its cap equals its floor. `retry_slow` is high whenever `stage` is nonzero.
- R5: At stage 2 the cap depends on the port's tags. A high-power port is capped at floor>>1. A non-critical port without the high-power tag is capped at floor-(floor>>2). A critical port without the high-power tag keeps its floor.
- R6: At stage 3 a port not marked critical is switched off: `port_off` is high and its cap is 0. Critical ports keep their stage-2 cap.
- R7: A port treated at normal has its cap equal to its maximum, `burst_ok` high and `neg_freeze` low.
- R8: When the stage falls, each port keeps its previous treatment until it is restored to the current stage. Ports are restored one at a time. The first restore happens `restore_gap`+1 edges after the last stage change, and each following restore happens `restore_gap`+1 edges after the one before. Ports without the high-power tag go first, lowest index first, then high-power ports, lowest index first.
- R9: Every stage change pulses `evt_valid` for one cycle. On escalation `evt_enter` is 1 and `evt_stage` is the new stage. On a fall `evt_enter` is 0 and `evt_stage` is the stage that was left. `evt_time` is a free-running cycle counter, so the difference between two events' times equals the cycles between them.
- R10: During reset the state is as follows: stage 0, all ports at maximum cap with burst allowed, no port off, no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_flat | input | NSENS*TW | Packed temperature readings, sensor k at bits k*TW |
| thr_t1 | input | TW | Stage 1 threshold |
| thr_t2 | input | TW | Stage 2 threshold |
| thr_t3 | input | TW | Stage 3 threshold |
| hold_cycles | input | HW | Hold count before each one-step fall |
| restore_gap | input | HW | Spacing count between port restores |
| port_critical | input | NPORT | Port stays on at stage 3 |
| port_highpwr | input | NPORT | Port is reduced first and restored last |
| floor_cap | input | NPORT*CAPW | Guaranteed floor per port |
| max_cap | input | NPORT*CAPW | Maximum cap (floor plus burst) per port |
| stage | output | 2 | Current global stage |
| retry_slow | output | 1 | Request to slow port retries |
| port_cap | output | NPORT*CAPW | Applied power cap per port |
| burst_ok | output | NPORT | Burst headroom allowed per port |
| neg_freeze | output | NPORT | Upward negotiation frozen per port |
| port_off | output | NPORT | Port disabled |
| evt_valid | output | 1 | One-cycle stage change event |
| evt_enter | output | 1 | Event direction, 1 for escalation |
| evt_stage | output | 2 | Stage entered or left |
| evt_time | output | TSW | Timestamp of the event |

## Verification
The bench targets five mistakes that the normal case would hide.

- A reading exactly at a threshold. A design using a strict comparison would report the lower stage.
- A jump from normal straight to stage 3. A design that climbs one level at a time would emit several events and spend cycles in stages 1 and 2.
- A cool spell broken by a single hot cycle. A design that does not restart its hold count would drop one cycle early.
- Recovery after a full cascade, where the bench watches the restore mask cycle by cycle. A design that releases all ports together, or picks high-power ports first, shows the wrong mask on an exact edge.
- The sign and level carried by each exit event, and the spacing of timestamps between events.

// File: rtl/thermal_derate_ctrl.sv
module thermal_derate_ctrl #(
  parameter int NPORT = 4,
  parameter int NSENS = 4,
  parameter int TW    = 10,
  parameter int CAPW  = 8,
  parameter int HW    = 16,
  parameter int TSW   = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSENS*TW-1:0]   temp_flat,
  input  logic [TW-1:0]         thr_t1,
  input  logic [TW-1:0]         thr_t2,
  input  logic [TW-1:0]         thr_t3,
  input  logic [HW-1:0]         hold_cycles,
  input  logic [HW-1:0]         restore_gap,
  input  logic [NPORT-1:0]      port_critical,
  input  logic [NPORT-1:0]      port_highpwr,
  input  logic [NPORT*CAPW-1:0] floor_cap,
  input  logic [NPORT*CAPW-1:0] max_cap,
  output logic [1:0]            stage,
  output logic                  retry_slow,
  output logic [NPORT*CAPW-1:0] port_cap,
  output logic [NPORT-1:0]      burst_ok,
  output logic [NPORT-1:0]      neg_freeze,
  output logic [NPORT-1:0]      port_off,
  output logic                  evt_valid,
  output logic                  evt_enter,
  output logic [1:0]            evt_stage,
  output logic [TSW-1:0]        evt_time
);
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [TW-1:0]  hot;
  logic [1:0]     tgt, stage_q;
  logic [HW-1:0]  hold_q, gap_q;
  logic [TSW-1:0] ts_q;
  logic [1:0]     pst [NPORT];
  logic [NPORT-1:0] pend;
  logic           sel_ok, up, dn;
  logic [IW-1:0]  sel_idx;

  always_comb begin
    hot = '0;
    for (int s = 0; s < NSENS; s++)
      if (temp_flat[s*TW +: TW] > hot) hot = temp_flat[s*TW +: TW];
  end

  assign tgt = (hot >= thr_t3) ? 2'd3 :
               (hot >= thr_t2) ? 2'd2 :
               (hot >= thr_t1) ? 2'd1 : 2'd0;

  assign up = tgt > stage_q;
  assign dn = (tgt < stage_q) && (hold_q == hold_cycles);

  always_comb begin
    for (int i = 0; i < NPORT; i++) pend[i] = pst[i] > stage_q;
  end

  always_comb begin
    sel_ok  = 1'b0;
    sel_idx = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (pend[i] && port_highpwr[i]) begin
        sel_ok  = 1'b1;
        sel_idx = IW'(i);
      end
    for (int i = NPORT - 1; i >= 0; i--)
      if (pend[i] && !port_highpwr[i]) begin
        sel_ok  = 1'b1;
        sel_idx = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= 2'd0;
      hold_q    <= '0;
      gap_q     <= '0;
      ts_q      <= '0;
      evt_valid <= 1'b0;
      evt_enter <= 1'b0;
      evt_stage <= 2'd0;
      evt_time  <= '0;
      for (int i = 0; i < NPORT; i++) pst[i] <= 2'd0;
    end else begin
      ts_q      <= ts_q + 1'b1;
      evt_valid <= 1'b0;
      if (up) begin
        stage_q   <= tgt;
        hold_q    <= '0;
        gap_q     <= '0;
        evt_valid <= 1'b1;
        evt_enter <= 1'b1;
        evt_stage <= tgt;
        evt_time  <= ts_q;
        for (int i = 0; i < NPORT; i++)
          if (pst[i] < tgt) pst[i] <= tgt;
      end else if (dn) begin
        stage_q   <= stage_q - 2'd1;
        hold_q    <= '0;
        gap_q     <= '0;
        evt_valid <= 1'b1;
        evt_enter <= 1'b0;
        evt_stage <= stage_q;
        evt_time  <= ts_q;
      end else begin
        if (tgt == stage_q) hold_q <= '0;
        else                hold_q <= hold_q + 1'b1;
        if (!sel_ok) gap_q <= '0;
        else if (gap_q == restore_gap) begin
          pst[sel_idx] <= stage_q;
          gap_q        <= '0;
        end else gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign stage      = stage_q;
  assign retry_slow = stage_q != 2'd0;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [CAPW-1:0] fl, mx, cap;
    assign fl = floor_cap[g*CAPW +: CAPW];
    assign mx = max_cap[g*CAPW +: CAPW];
    always_comb begin
      case (pst[g])
        2'd0:    cap = mx;
        2'd1:    cap = fl;
        default: cap = port_highpwr[g] ? (fl >> 1) :
                       port_critical[g] ? fl : (fl - (fl >> 2));
      endcase
      if (pst[g] == 2'd3 && !port_critical[g]) cap = '0;
    end
    assign port_cap[g*CAPW +: CAPW] = cap;
    assign port_off[g]   = (pst[g] == 2'd3) && !port_critical[g];
    assign burst_ok[g]   = pst[g] == 2'd0;
    assign neg_freeze[g] = pst[g] != 2'd0;
  end
endmodule

// File: rtl/thermal_derate_chk.sv
module thermal_derate_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       stage,
  input logic [NPORT-1:0] port_critical,
  input logic [NPORT-1:0] burst_ok,
  input logic [NPORT-1:0] port_off,
  input logic             evt_valid,
  input logic             evt_enter,
  input logic [1:0]       evt_stage
);
  // R3
  single_step_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage < $past(stage)) |-> (stage == $past(stage) - 2'd1));

  // R9
  change_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != $past(stage)) |-> evt_valid);

  // R9
  enter_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_enter) |-> (evt_stage == stage));

  // R9
  exit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_enter) |-> (evt_stage == stage + 2'd1));

  // R6
  critical_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off & port_critical) == '0);

  // R4
  no_burst_when_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != 2'd0) |-> (burst_ok == '0));
endmodule

bind thermal_derate_ctrl thermal_derate_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage(stage), .port_critical(port_critical),
  .burst_ok(burst_ok), .port_off(port_off), .evt_valid(evt_valid),
  .evt_enter(evt_enter), .evt_stage(evt_stage)
);

// File: tb/thermal_derate_ctrl_bench.sv
module thermal_derate_ctrl_bench;
  localparam int NPORT = 4, NSENS = 4, TW = 10, CAPW = 8, HW = 16, TSW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] t [NSENS];
  logic [HW-1:0] hold_cycles, restore_gap;
  logic [1:0] stage, evt_stage;
  logic retry_slow, evt_valid, evt_enter;
  logic [NPORT*CAPW-1:0] port_cap;
  logic [NPORT-1:0] burst_ok, neg_freeze, port_off;
  logic [TSW-1:0] evt_time;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [NPORT-1:0] CRIT = 4'b0011;
  localparam logic [NPORT-1:0] HP   = 4'b0101;
  localparam int FL [NPORT] = '{40, 60, 80, 100};
  localparam int MX [NPORT] = '{90, 90, 120, 150};

  // {s3, s2, s1, s0, expected stage}
  localparam logic [4*TW+1:0] VEC [6] = '{
    {10'd10, 10'd30, 10'd20, 10'd80, 2'd0},
    {10'd10, 10'd30, 10'd100, 10'd80, 2'd1},
    {10'd10, 10'd149, 10'd20, 10'd80, 2'd1},
    {10'd150, 10'd30, 10'd20, 10'd80, 2'd2},
    {10'd10, 10'd30, 10'd20, 10'd199, 2'd2},
    {10'd10, 10'd200, 10'd20, 10'd80, 2'd3}
  };

  always #10 clk = ~clk;

  thermal_derate_ctrl #(.NPORT(NPORT), .NSENS(NSENS), .TW(TW), .CAPW(CAPW),
                        .HW(HW), .TSW(TSW)) u_thermal_derate_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_flat({t[3], t[2], t[1], t[0]}),
    .thr_t1(10'd100), .thr_t2(10'd150), .thr_t3(10'd200),
    .hold_cycles(hold_cycles), .restore_gap(restore_gap),
    .port_critical(CRIT), .port_highpwr(HP),
    .floor_cap({8'd100, 8'd80, 8'd60, 8'd40}),
    .max_cap({8'd150, 8'd120, 8'd90, 8'd90}),
    .stage(stage), .retry_slow(retry_slow), .port_cap(port_cap),
    .burst_ok(burst_ok), .neg_freeze(neg_freeze), .port_off(port_off),
    .evt_valid(evt_valid), .evt_enter(evt_enter), .evt_stage(evt_stage),
    .evt_time(evt_time)
  );

  function automatic int ecap(int p, int st);
    if (st == 0) return MX[p];
    if (st == 1) return FL[p];
    if (st == 3 && !CRIT[p]) return 0;
    if (HP[p]) return FL[p] / 2;
    if (CRIT[p]) return FL[p];
    return FL[p] - FL[p] / 4;
  endfunction

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic set_t(input int a, input int b, input int c, input int d);
    t[0] = TW'(a); t[1] = TW'(b); t[2] = TW'(c); t[3] = TW'(d);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int h, input int g);
    rst_n = 1'b0;
    hold_cycles = HW'(h);
    restore_gap = HW'(g);
    set_t(0, 0, 0, 0);
    edges(3);
    rst_n = 1'b1;
  endtask

  task automatic port_all(input int st, input string rq);
    for (int p = 0; p < NPORT; p++) begin
      chk({rq, " cap"}, port_cap[p*CAPW +: CAPW], ecap(p, st));
      chk({rq, " burst"}, burst_ok[p], st == 0);
      chk({rq, " freeze"}, neg_freeze[p], st != 0);
      chk({rq, " off"}, port_off[p], st == 3 && !CRIT[p]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev, ta, tb;
    string rq;
    hold_cycles = '0; restore_gap = '0;
    set_t(0, 0, 0, 0);
    @(negedge clk);
    // R10 reset state
    chk("R10 stage", stage, 0);
    chk("R10 evt", evt_valid, 0);
    port_all(0, "R10");

    // R1 table walk, escalating only
    do_reset(5, 5);
    prev = 0;
    for (int v = 0; v < 6; v++) begin
      set_t(VEC[v][2+:TW], VEC[v][2+TW+:TW], VEC[v][2+2*TW+:TW], VEC[v][2+3*TW+:TW]);
      edges(1);
      chk("R1 stage", stage, VEC[v][1:0]);
      chk("R4 retry", retry_slow, VEC[v][1:0] != 0);
      case (VEC[v][1:0])
        2'd0: rq = "R7"; 2'd1: rq = "R4"; 2'd2: rq = "R5"; default: rq = "R6";
      endcase
      port_all(VEC[v][1:0], rq);
      chk("R9 evt", evt_valid, VEC[v][1:0] != prev);
      if (VEC[v][1:0] != prev) chk("R9 enter", evt_enter, 1);
      prev = VEC[v][1:0];
    end

    // R2 direct jump to stage 3, single event
    do_reset(2, 20);
    set_t(0, 0, 250, 0);
    edges(1);
    chk("R2 stage", stage, 3);
    chk("R9 evt", evt_valid, 1);
    chk("R9 enter", evt_enter, 1);
    chk("R9 lvl", evt_stage, 3);
    edges(1);
    chk("R2 one event", evt_valid, 0);
    chk("R2 stage hold", stage, 3);

    // R3 cascade, R9 exit events, R8 staggered restore
    set_t(0, 0, 0, 0);
    edges(2);
    chk("R3 early", stage, 3);
    edges(1);
    chk("R3 drop", stage, 2);
    chk("R9 exit", evt_valid, 1);
    chk("R9 exit dir", evt_enter, 0);
    chk("R9 exit lvl", evt_stage, 3);
    ta = int'(evt_time);
    edges(3);
    chk("R3 drop2", stage, 1);
    chk("R9 exit lvl2", evt_stage, 2);
    tb = int'(evt_time);
    chk("R9 time", tb - ta, 3);
    edges(3);
    chk("R3 drop3", stage, 0);
    chk("R8 held burst", burst_ok, 4'b0000);
    chk("R8 held off", port_off, 4'b1100);
    edges(20);
    chk("R8 pre1", burst_ok, 4'b0000);
    edges(1);
    chk("R8 first low-power", burst_ok, 4'b0010);
    edges(20);
    chk("R8 gap", burst_ok, 4'b0010);
    edges(1);
    chk("R8 second low-power", burst_ok, 4'b1010);
    chk("R8 off", port_off, 4'b0100);
    edges(21);
    chk("R8 first high-power", burst_ok, 4'b1011);
    edges(21);
    chk("R8 last", burst_ok, 4'b1111);
    chk("R8 cap p2", port_cap[2*CAPW +: CAPW], 120);

    // R3 interrupted hold restarts count
    do_reset(2, 0);
    set_t(120, 0, 0, 0);
    edges(1);
    chk("R3 at1", stage, 1);
    set_t(0, 0, 0, 0);
    edges(2);
    chk("R3 still1", stage, 1);
    set_t(0, 0, 0, 120);
    edges(1);
    set_t(0, 0, 0, 0);
    edges(2);
    chk("R3 restart", stage, 1);
    edges(1);
    chk("R3 fell", stage, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule